// File: doc/BRIEF.md
# Vector and Page Address Constant Generator

This block supplies the fixed address bytes that an 8-bit processor core places on its address buses when it does not take the address from a register. The high byte can be forced to the stack-page prefix or the zero-page prefix. During a two-byte interrupt, reset or NMI vector fetch, the block produces both address bytes. Every constant starts from an all-ones bus value. Individual bits are then pulled low, so several pull-down enables can act at the same time without a lookup table.

A small sequencer runs each vector fetch. When a fetch is requested, it latches the vector type and spends one cycle on the first (low) byte of the vector and one cycle on the second (high) byte. In the cycle after that it pulses a done flag and returns to idle. When neither a fetch nor a page prefix is active, both output bytes pass through the address driven on the pass-through inputs.

Top module: `addr_const_gen`

## Requirements
- R1: After reset the sequencer is idle: `fetch_busy`, `fetch_first` and `fetch_done` are 0, and with `page_sel`=00 both outputs equal the pass-through inputs.
- R2: When idle with `page_sel` 00 or 11 (11 is reserved), `adh_out`=`addr_hi_in` and `adl_out`=`addr_lo_in`.
- R3: When idle with `page_sel`=01 (stack page), `adh_out`=0x01 and `adl_out`=`addr_lo_in`.
- R4: When idle with `page_sel`=10 (zero page), `adh_out`=0x00 and `adl_out`=`addr_lo_in`.
- R5: If `fetch_start`=1 with `vec_sel`≠00 at a rising edge while idle, the cycle after that edge is the first access (`fetch_busy`=1, `fetch_first`=1). The next cycle is the second access (`fetch_busy`=1, `fetch_first`=0). The cycle after that has `fetch_done`=1 and `fetch_busy`=0. `fetch_done` stays high for exactly one cycle.
- R6: While a fetch is busy, `adh_out`=0xFF whatever `page_sel` holds.
- R7: An IRQ vector fetch (`vec_sel`=01) gives `adl_out`=0xFE on the first access and 0xFF on the second.
- R8: A reset vector fetch (`vec_sel`=10) gives `adl_out`=0xFC and then 0xFD.
- R9: An NMI vector fetch (`vec_sel`=11) gives `adl_out`=0xFA and then 0xFB.
- R10: `fetch_start` is ignored while busy and when `vec_sel`=00. The vector type is latched at the start, so a later change to `vec_sel` has no effect on a running fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | 2 | Page prefix select: 00 none, 01 stack, 10 zero, 11 reserved (none) |
| vec_sel | input | 2 | Vector type: 00 none, 01 IRQ, 10 reset, 11 NMI |
| fetch_start | input | 1 | Request a two-byte vector fetch |
| addr_hi_in | input | 8 | Pass-through high address byte |
| addr_lo_in | input | 8 | Pass-through low address byte |
| adh_out | output | 8 | High address bus value |
| adl_out | output | 8 | Low address bus value |
| fetch_busy | output | 1 | Vector fetch in progress |
| fetch_first | output | 1 | Current cycle is the first access of the fetch |
| fetch_done | output | 1 | One-cycle pulse after the second access |

## Verification
The hardest situation to reach is a running fetch whose inputs are disturbed while it runs. This covers a start request held high into the second access, and a vector type changed after it was latched. The stimulus requests such fetches with a random page select and random pass-through bytes. Some of them keep the start line high through the first access and replace `vec_sel` with a random value. The bench then checks that the sequence order and both vector bytes still follow the latched type.

// File: rtl/addr_const_pkg.sv
package addr_const_pkg;

   typedef enum logic [1:0] {
      PG_NONE  = 2'b00,
      PG_STACK = 2'b01,
      PG_ZERO  = 2'b10,
      PG_RSVD  = 2'b11
   } page_mode_e;

   typedef enum logic [1:0] {
      VK_NONE  = 2'b00,
      VK_IRQ   = 2'b01,
      VK_RESET = 2'b10,
      VK_NMI   = 2'b11
   } vec_kind_e;

   typedef enum logic [1:0] {
      FS_IDLE   = 2'b00,
      FS_FIRST  = 2'b01,
      FS_SECOND = 2'b10
   } fetch_st_e;

   // Low-bus bit positions pulled per vector kind; bit 0 marks the first access.
   localparam int unsigned LO_FIRST_BIT = 0;
   localparam int unsigned LO_RST_BIT   = 1;
   localparam int unsigned LO_NMI_BIT   = 2;

endpackage

// File: rtl/vec_fetch_seq.sv
module vec_fetch_seq
   import addr_const_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  vec_kind_e kind_in,
   output vec_kind_e kind_act,
   output logic      busy,
   output logic      first,
   output logic      done
);

   fetch_st_e state_q;
   vec_kind_e kind_q;
   logic      done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         kind_q  <= VK_NONE;
         done_q  <= 1'b0;
      end else begin
         done_q <= (state_q == FS_SECOND);
         case (state_q)
            FS_IDLE: begin
               if (start && kind_in != VK_NONE) begin
                  state_q <= FS_FIRST;
                  kind_q  <= kind_in;
               end
            end
            FS_FIRST:  state_q <= FS_SECOND;
            FS_SECOND: state_q <= FS_IDLE;
            default:   state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != FS_IDLE);
   assign first    = (state_q == FS_FIRST);
   assign done     = done_q;
   assign kind_act = busy ? kind_q : VK_NONE;

   // R5: first access is always followed by the second
   a_r5_first_then_second: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_FIRST) |=> (state_q == FS_SECOND));
   // R5: done follows the second access
   a_r5_done_after_second: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_SECOND) |=> (done && !busy));
   // R5: done is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10: latched kind cannot change mid-fetch
   a_r10_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state_q != FS_FIRST) |-> $stable(kind_q));

endmodule

// File: rtl/hi_pull_gen.sv
module hi_pull_gen
   import addr_const_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  page_mode_e page,
   input  logic       vec_busy,
   output logic [W-1:0] pull,
   output logic       const_en
);

   logic pull_upper;
   logic pull_lsb;

   always_comb begin
      pull_upper = 1'b0;
      pull_lsb   = 1'b0;
      if (!vec_busy) begin
         pull_upper = (page == PG_STACK) || (page == PG_ZERO);
         pull_lsb   = (page == PG_ZERO);
      end
   end

   assign const_en = vec_busy || pull_upper;

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         assign pull[b] = pull_lsb;
      end else begin : g_up
         assign pull[b] = pull_upper;
      end
   end

endmodule

// File: rtl/lo_pull_gen.sv
module lo_pull_gen
   import addr_const_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  vec_kind_e kind,
   input  logic      first,
   output logic [W-1:0] pull
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == LO_FIRST_BIT) begin : g_first
         assign pull[b] = first && (kind != VK_NONE);
      end else if (b == LO_RST_BIT) begin : g_rst
         assign pull[b] = (kind == VK_RESET);
      end else if (b == LO_NMI_BIT) begin : g_nmi
         assign pull[b] = (kind == VK_NMI);
      end else begin : g_none
         assign pull[b] = 1'b0;
      end
   end

endmodule

// File: rtl/addr_const_gen.sv
module addr_const_gen
   import addr_const_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        page_sel,
   input  logic [1:0]        vec_sel,
   input  logic              fetch_start,
   input  logic [ADDR_W-1:0] addr_hi_in,
   input  logic [ADDR_W-1:0] addr_lo_in,
   output logic [ADDR_W-1:0] adh_out,
   output logic [ADDR_W-1:0] adl_out,
   output logic              fetch_busy,
   output logic              fetch_first,
   output logic              fetch_done
);

   localparam logic [ADDR_W-1:0] BUS_IDLE = {ADDR_W{1'b1}};

   if (ADDR_W < 3) begin : g_bad_width
      $error("addr_const_gen: ADDR_W must be at least 3");
   end

   vec_kind_e         kind_act;
   logic              busy, first;
   logic [ADDR_W-1:0] hi_pull, lo_pull;
   logic              hi_const;
   logic [ADDR_W-1:0] adh_c, adl_c;

   vec_fetch_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fetch_start),
      .kind_in (vec_kind_e'(vec_sel)),
      .kind_act(kind_act),
      .busy    (busy),
      .first   (first),
      .done    (fetch_done)
   );

   hi_pull_gen #(.W(ADDR_W)) u_hi (
      .page    (page_mode_e'(page_sel)),
      .vec_busy(busy),
      .pull    (hi_pull),
      .const_en(hi_const)
   );

   lo_pull_gen #(.W(ADDR_W)) u_lo (
      .kind (kind_act),
      .first(first),
      .pull (lo_pull)
   );

   assign adh_c = hi_const ? (BUS_IDLE & ~hi_pull) : addr_hi_in;
   assign adl_c = busy     ? (BUS_IDLE & ~lo_pull) : addr_lo_in;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            adh_out <= '0;
            adl_out <= '0;
         end else begin
            adh_out <= adh_c;
            adl_out <= adl_c;
         end
      end
   end else begin : g_comb_out
      assign adh_out = adh_c;
      assign adl_out = adl_c;
   end

   assign fetch_busy  = busy;
   assign fetch_first = first;

   // R6: high bus held at all ones during a vector fetch
   a_r6_hi_ones: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (adh_c == BUS_IDLE));
   // R3: stack prefix when idle
   a_r3_stack_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && page_sel == 2'b01) |-> (adh_c == ADDR_W'(1)));
   // R4: zero-page prefix when idle
   a_r4_zero_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && page_sel == 2'b10) |-> (adh_c == '0));
   // R7: first byte of every vector is even, second odd
   a_r7_lsb_order: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (adl_c[0] == !first));
   // R2: idle low bus passes through
   a_r2_lo_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (adl_c == addr_lo_in));

endmodule

// File: tb/sim_addr_const_gen.sv
`timescale 1ns/1ps
module sim_addr_const_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] page_sel = 2'b00;
   logic [1:0] vec_sel = 2'b00;
   logic       fetch_start = 1'b0;
   logic [7:0] addr_hi_in = 8'h00;
   logic [7:0] addr_lo_in = 8'h00;
   logic [7:0] adh_out, adl_out;
   logic       fetch_busy, fetch_first, fetch_done;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   addr_const_gen u0 (
      .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .vec_sel(vec_sel),
      .fetch_start(fetch_start), .addr_hi_in(addr_hi_in), .addr_lo_in(addr_lo_in),
      .adh_out(adh_out), .adl_out(adl_out), .fetch_busy(fetch_busy),
      .fetch_first(fetch_first), .fetch_done(fetch_done)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_hi_idle(logic [1:0] ps, logic [7:0] hi);
      case (ps)
         2'b01:   return 8'h01;
         2'b10:   return 8'h00;
         default: return hi;
      endcase
   endfunction

   function automatic logic [7:0] exp_vec_lo(logic [1:0] k, bit first_acc);
      case (k)
         2'b01:   return first_acc ? 8'hFE : 8'hFF;
         2'b10:   return first_acc ? 8'hFC : 8'hFD;
         default: return first_acc ? 8'hFA : 8'hFB;
      endcase
   endfunction

   task automatic check_idle(string req);
      chk(req, {5'd0, fetch_busy, fetch_first, fetch_done}, 8'h00);
      chk(req, adh_out, exp_hi_idle(page_sel, addr_hi_in));
      chk(req, adl_out, addr_lo_in);
   endtask

   // One full vector fetch; disturb holds start and scrambles vec_sel mid-fetch
   task automatic do_fetch(logic [1:0] k, bit disturb);
      @(negedge clk);
      vec_sel = k;
      fetch_start = 1'b1;
      page_sel = 2'($urandom);
      addr_hi_in = 8'($urandom);
      addr_lo_in = 8'($urandom);
      @(posedge clk); #1;
      if (disturb) vec_sel = 2'($urandom);
      else fetch_start = 1'b0;
      chk("R5 first access flags", {6'd0, fetch_busy, fetch_first}, 8'h03);
      chk("R6 high byte during first", adh_out, 8'hFF);
      chk("R7/R8/R9 first vector byte", adl_out, exp_vec_lo(k, 1'b1));
      @(posedge clk); #1;
      fetch_start = 1'b0;
      page_sel = 2'($urandom);
      chk("R5 R10 second access flags", {6'd0, fetch_busy, fetch_first}, 8'h02);
      chk("R6 high byte during second", adh_out, 8'hFF);
      chk("R7/R8/R9 R10 second vector byte", adl_out, exp_vec_lo(k, 1'b0));
      @(posedge clk); #1;
      chk("R5 done pulse", {6'd0, fetch_busy, fetch_done}, 8'h01);
      chk("R2 pass after fetch", adl_out, addr_lo_in);
      @(posedge clk); #1;
      chk("R5 done single cycle", {7'd0, fetch_done}, 8'h00);
   endtask

   initial begin
      #(4ns * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      addr_hi_in = 8'h5A; addr_lo_in = 8'hC3;
      @(posedge clk); #1;
      check_idle("R1 reset state");

      // R2 R3 R4 directed prefixes
      for (int p = 0; p < 4; p++) begin
         @(negedge clk);
         page_sel = 2'(p);
         addr_hi_in = 8'hA5; addr_lo_in = 8'h3C;
         #1;
         check_idle(p == 1 ? "R3 stack prefix" : p == 2 ? "R4 zero prefix" : "R2 pass-through");
      end

      // R2 R3 R4 random idle patterns
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         page_sel = 2'($urandom);
         addr_hi_in = 8'($urandom);
         addr_lo_in = 8'($urandom);
         #1;
         check_idle("R2/R3/R4 random idle");
      end

      // R10: start with no vector kind is ignored
      @(negedge clk);
      vec_sel = 2'b00; fetch_start = 1'b1; page_sel = 2'b01;
      @(posedge clk); #1;
      fetch_start = 1'b0;
      check_idle("R10 start with kind none");

      // R7 R8 R9 directed, each vector kind in order
      do_fetch(2'b01, 1'b0);
      do_fetch(2'b10, 1'b0);
      do_fetch(2'b11, 1'b0);
      // R10 disturbed fetches per kind
      do_fetch(2'b01, 1'b1);
      do_fetch(2'b10, 1'b1);
      do_fetch(2'b11, 1'b1);

      // Random mix
      for (int i = 0; i < 30; i++) begin
         logic [1:0] k;
         k = 2'($urandom_range(1, 3));
         do_fetch(k, 1'($urandom));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule